// File: doc/BRIEF.md
# Attention and Command Issue Sequencer

This block sits on the host side of a disk adapter's register port and turns a single request into the exact series of register writes the adapter expects. Every request starts with an attention handshake: interrupts are masked in the control register, the adapter's busy flag is polled until it drops, the attention byte (attention code plus target device) is written, and interrupts are unmasked again. The busy poll is left out when the request acknowledges a reset-complete event, because the adapter still shows busy at that point.

When the request is a command request, the sequencer then pushes a command block of two or four 16-bit words into the command interface register. The first word is built at issue time from the length, option bits, device number and command code. After every word it polls the interface-full flag until the adapter has taken the word. Every poll is bounded by a retry limit, and retries are spaced by a delay count. The polled and interrupt-driven modes each have their own delay setting. The block reports busy, a one-cycle done pulse, or a one-cycle timeout pulse that aborts the request. Waiting for the command's completion interrupt is left to other logic.

Top module: `attn_cmd_seq`

## Requirements
- R1: A request (`req_valid` high) is taken only when the sequencer is idle; request inputs seen while busy have no effect on any register write or on the outcome, and no register write occurs while idle.
- R2: The first write of every request, one cycle after acceptance, is the control register (`reg_sel`=0) with data 0.
- R3: The busy poll checks `adp_busy` once after a wait of D cycles and then every D+1 cycles, where D is `dly_polled` when `poll_mode`=1 and `dly_irq` otherwise; the attention write follows in the cycle after the first check that sees busy low.
- R4: When `req_ack_rst` is set, the busy poll is skipped and the attention write comes right after the masking write, whatever `adp_busy` shows.
- R5: The attention write (`reg_sel`=1) carries the device number in bits 7:5 and the attention code in bits 4:0, other bits zero; device 7 addresses the adapter itself.
- R6: The cycle after the attention write, the control register is written with the interrupt-enable value (default 0x0080) only.
- R7: Command word 0 is {length[15:14], options[13:8], device[7:5], code[4:0]}, with length 00 for a two-word and 01 for a four-word block.
- R8: A command request (`req_cmd`) writes the command register (`reg_sel`=2) starting the cycle after the unmask write, words 0,1 for a short block and 0..3 for a long block, taking words 1..3 from `req_arg1`..`req_arg3` as latched at acceptance.
- R9: After each command word, `adp_cif_full` is polled with the same spacing as R3; the next word, or completion after the last, follows the cycle after the first check that sees the flag low; two command writes are never back to back.
- R10: Each poll makes at most MAX_POLLS checks; if all see the flag set, `seq_timeout` pulses for one cycle, the sequencer goes idle and no further write of that request occurs.
- R11: `seq_done` pulses for one cycle when the request finishes (the cycle after the unmask write for a plain attention, after the final accepted poll for a command), never together with `seq_timeout`, and with `seq_busy` low.
- R12: After reset, `reg_wr`, `seq_busy`, `seq_done` and `seq_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_attn | input | 5 | Attention code |
| req_dev | input | 3 | Target device number |
| req_ack_rst | input | 1 | Request acknowledges reset completion: skip busy poll |
| req_cmd | input | 1 | Follow the attention with a command block |
| req_long | input | 1 | Command block is four words (else two) |
| req_opts | input | 6 | Command option bits |
| req_code | input | 5 | Command code |
| req_arg1 | input | 16 | Command word 1 |
| req_arg2 | input | 16 | Command word 2 |
| req_arg3 | input | 16 | Command word 3 |
| poll_mode | input | 1 | 1 selects the polled-mode retry delay |
| dly_polled | input | DLY_W | Retry spacing in polled mode |
| dly_irq | input | DLY_W | Retry spacing in interrupt-driven mode |
| adp_busy | input | 1 | Adapter busy flag |
| adp_cif_full | input | 1 | Adapter command interface register full |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 2 | Target: 0 control, 1 attention, 2 command |
| reg_wdata | output | 16 | Write data |
| seq_busy | output | 1 | Request in progress |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_timeout | output | 1 | One-cycle poll timeout pulse |

## Verification
The bench builds the sequencer with MAX_POLLS=4 and a 3-bit delay, so every retry limit is reached within a few tens of cycles. That lets it sweep the flag-release point across every check position, including one past the last, for both polls and both block lengths. With delays from 0 to 7 and all eight device numbers, the exact cycle of every write and of the done or timeout pulse is predicted arithmetically and compared. Requests injected mid-run confirm that nothing is taken while busy.

// File: rtl/attn_seq_pkg.sv
package attn_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MASK,
    ST_WAIT_RDY,
    ST_ATTN,
    ST_UNMASK,
    ST_WORD,
    ST_WAIT_ACC
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ATTN = 2'd1,
    SEL_CMD  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int DLY_W     = 8,
  parameter int MAX_POLLS = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             retry,
  input  logic [DLY_W-1:0] dly,
  output logic             chk,
  output logic             last
);
  localparam int TRY_W = $clog2(MAX_POLLS + 1);

  logic [DLY_W-1:0] dcnt_q, dcnt_n;
  logic [TRY_W-1:0] tries_q, tries_n;

  always_comb begin
    dcnt_n  = dcnt_q;
    tries_n = tries_q;
    if (load) begin
      dcnt_n  = dly;
      tries_n = '0;
    end else if (run) begin
      if (dcnt_q != '0) begin
        dcnt_n = dcnt_q - 1'b1;
      end else if (retry) begin
        dcnt_n  = dly;
        tries_n = tries_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      tries_q <= '0;
    end else if (load || run) begin
      dcnt_q  <= dcnt_n;
      tries_q <= tries_n;
    end
  end

  assign chk  = run && (dcnt_q == '0);
  assign last = (tries_q == TRY_W'(MAX_POLLS - 1));
endmodule

// File: rtl/seq_word_fmt.sv
module seq_word_fmt (
  input  logic        long_blk,
  input  logic [5:0]  opts,
  input  logic [2:0]  dev,
  input  logic [4:0]  code,
  input  logic [15:0] arg1,
  input  logic [15:0] arg2,
  input  logic [15:0] arg3,
  input  logic [1:0]  idx,
  output logic [15:0] word
);
  logic [15:0] head;

  assign head = {1'b0, long_blk, opts, dev, code};

  always_comb begin
    case (idx)
      2'd0:    word = head;
      2'd1:    word = arg1;
      2'd2:    word = arg2;
      default: word = arg3;
    endcase
  end
endmodule

// File: rtl/attn_cmd_seq.sv
module attn_cmd_seq
  import attn_seq_pkg::*;
#(
  parameter int          DLY_W     = 8,
  parameter int          MAX_POLLS = 10000,
  parameter logic [7:0]  CTRL_IE   = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [4:0]       req_attn,
  input  logic [2:0]       req_dev,
  input  logic             req_ack_rst,
  input  logic             req_cmd,
  input  logic             req_long,
  input  logic [5:0]       req_opts,
  input  logic [4:0]       req_code,
  input  logic [15:0]      req_arg1,
  input  logic [15:0]      req_arg2,
  input  logic [15:0]      req_arg3,
  input  logic             poll_mode,
  input  logic [DLY_W-1:0] dly_polled,
  input  logic [DLY_W-1:0] dly_irq,
  input  logic             adp_busy,
  input  logic             adp_cif_full,
  output logic             reg_wr,
  output logic [1:0]       reg_sel,
  output logic [15:0]      reg_wdata,
  output logic             seq_busy,
  output logic             seq_done,
  output logic             seq_timeout
);
  seq_state_e st_q, st_n;
  reg_sel_e   sel_c;

  logic [4:0]  l_attn, l_code;
  logic [2:0]  l_dev;
  logic        l_ack, l_cmd, l_long;
  logic [5:0]  l_opts;
  logic [15:0] l_arg1, l_arg2, l_arg3;
  logic [1:0]  idx_q, idx_n;
  logic        done_q, tmo_q;

  logic        lat_en, wr_c, done_set, tmo_set;
  logic [15:0] wdat_c, word_c;
  logic        tload, trun, tretry, tchk, tlast;
  logic [DLY_W-1:0] dly_sel;
  logic [1:0]  last_idx;

  assign dly_sel  = poll_mode ? dly_polled : dly_irq;
  assign last_idx = l_long ? 2'd3 : 2'd1;

  seq_poll_timer #(.DLY_W(DLY_W), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .run(trun), .retry(tretry),
    .dly(dly_sel), .chk(tchk), .last(tlast)
  );

  seq_word_fmt u_fmt (
    .long_blk(l_long), .opts(l_opts), .dev(l_dev), .code(l_code),
    .arg1(l_arg1), .arg2(l_arg2), .arg3(l_arg3), .idx(idx_q), .word(word_c)
  );

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    lat_en   = 1'b0;
    wr_c     = 1'b0;
    sel_c    = SEL_CTRL;
    wdat_c   = '0;
    tload    = 1'b0;
    trun     = 1'b0;
    tretry   = 1'b0;
    done_set = 1'b0;
    tmo_set  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          lat_en = 1'b1;
          st_n   = ST_MASK;
        end
      end
      ST_MASK: begin
        wr_c = 1'b1;
        if (l_ack) begin
          st_n = ST_ATTN;
        end else begin
          st_n  = ST_WAIT_RDY;
          tload = 1'b1;
        end
      end
      ST_WAIT_RDY: begin
        trun = 1'b1;
        if (tchk) begin
          if (!adp_busy) begin
            st_n = ST_ATTN;
          end else if (tlast) begin
            st_n    = ST_IDLE;
            tmo_set = 1'b1;
          end else begin
            tretry = 1'b1;
          end
        end
      end
      ST_ATTN: begin
        wr_c   = 1'b1;
        sel_c  = SEL_ATTN;
        wdat_c = {8'h00, l_dev, l_attn};
        st_n   = ST_UNMASK;
      end
      ST_UNMASK: begin
        wr_c   = 1'b1;
        wdat_c = {8'h00, CTRL_IE};
        idx_n  = 2'd0;
        if (l_cmd) begin
          st_n = ST_WORD;
        end else begin
          st_n     = ST_IDLE;
          done_set = 1'b1;
        end
      end
      ST_WORD: begin
        wr_c   = 1'b1;
        sel_c  = SEL_CMD;
        wdat_c = word_c;
        tload  = 1'b1;
        st_n   = ST_WAIT_ACC;
      end
      ST_WAIT_ACC: begin
        trun = 1'b1;
        if (tchk) begin
          if (!adp_cif_full) begin
            if (idx_q == last_idx) begin
              st_n     = ST_IDLE;
              done_set = 1'b1;
            end else begin
              idx_n = idx_q + 1'b1;
              st_n  = ST_WORD;
            end
          end else if (tlast) begin
            st_n    = ST_IDLE;
            tmo_set = 1'b1;
          end else begin
            tretry = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      done_q <= done_set;
      tmo_q  <= tmo_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_attn <= '0; l_dev <= '0; l_ack <= 1'b0; l_cmd <= 1'b0;
      l_long <= 1'b0; l_opts <= '0; l_code <= '0;
      l_arg1 <= '0; l_arg2 <= '0; l_arg3 <= '0;
    end else if (lat_en) begin
      l_attn <= req_attn; l_dev <= req_dev; l_ack <= req_ack_rst;
      l_cmd  <= req_cmd;  l_long <= req_long; l_opts <= req_opts;
      l_code <= req_code; l_arg1 <= req_arg1; l_arg2 <= req_arg2;
      l_arg3 <= req_arg3;
    end
  end

  assign reg_wr      = wr_c;
  assign reg_sel     = sel_c;
  assign reg_wdata   = wdat_c;
  assign seq_busy    = (st_q != ST_IDLE);
  assign seq_done    = done_q;
  assign seq_timeout = tmo_q;
endmodule

// File: rtl/attn_cmd_seq_chk.sv
module attn_cmd_seq_chk #(
  parameter logic [7:0] CTRL_IE = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        adp_busy,
  input logic        adp_cif_full,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [15:0] reg_wdata,
  input logic        seq_busy,
  input logic        seq_done,
  input logic        seq_timeout
);
  assert_unmask_after_attn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |=> (reg_wr && reg_sel == 2'd0 && reg_wdata == {8'h00, CTRL_IE}));

  assert_mask_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && reg_wdata == 16'h0000) |-> !$past(seq_busy));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !reg_wr);

  assert_no_b2b_words_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2) |=> !(reg_wr && reg_sel == 2'd2));

  assert_timeout_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_timeout |-> $past(adp_busy || adp_cif_full));

  assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_done, seq_timeout}));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_busy);
endmodule

bind attn_cmd_seq attn_cmd_seq_chk #(.CTRL_IE(CTRL_IE)) u_chk (
  .clk(clk), .rst_n(rst_n), .adp_busy(adp_busy), .adp_cif_full(adp_cif_full),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .seq_busy(seq_busy), .seq_done(seq_done), .seq_timeout(seq_timeout)
);

// File: tb/attn_cmd_seq_bench.sv
module attn_cmd_seq_bench;
  localparam int MAXP = 4;
  localparam int DW   = 3;

  logic clk, rst_n;
  logic req_valid, req_ack_rst, req_cmd, req_long, poll_mode;
  logic [4:0] req_attn, req_code;
  logic [2:0] req_dev;
  logic [5:0] req_opts;
  logic [15:0] req_arg1, req_arg2, req_arg3;
  logic [DW-1:0] dly_polled, dly_irq;
  logic adp_busy, adp_cif_full;
  logic reg_wr, seq_busy, seq_done, seq_timeout;
  logic [1:0] reg_sel;
  logic [15:0] reg_wdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  attn_cmd_seq #(.DLY_W(DW), .MAX_POLLS(MAXP)) u_attn_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_attn(req_attn),
    .req_dev(req_dev), .req_ack_rst(req_ack_rst), .req_cmd(req_cmd),
    .req_long(req_long), .req_opts(req_opts), .req_code(req_code),
    .req_arg1(req_arg1), .req_arg2(req_arg2), .req_arg3(req_arg3),
    .poll_mode(poll_mode), .dly_polled(dly_polled), .dly_irq(dly_irq),
    .adp_busy(adp_busy), .adp_cif_full(adp_cif_full), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .seq_busy(seq_busy),
    .seq_done(seq_done), .seq_timeout(seq_timeout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int e_sel[16], e_dat[16], e_cyc[16];
  int g_sel[16], g_dat[16], g_cyc[16];

  // One request; K: busy low from cycle K (0 = always low), H: cycles cif stays full after a word
  task automatic run(input bit mode, input int dp, input int di, input bit ack,
                     input bit cmd, input bit lng, input int dev, input int attn,
                     input int code, input int opts, input int K, input int H,
                     input bit poke, input string tag);
    int d, ne, ng, a, c, wcy, nw, kind, endc, gkind, gend, pulses, n;
    bit ok, stop, fin;
    int cif_until;
    int words[4];
    d = mode ? dp : di;
    words[0] = (lng ? 32'h4000 : 0) | (opts << 8) | (dev << 5) | code;
    words[1] = 16'h1100 + H; words[2] = 16'h2200 + dev; words[3] = 16'h3300 + code;
    // expected model
    ne = 0; kind = 0; endc = 0;
    e_sel[ne] = 0; e_dat[ne] = 0; e_cyc[ne] = 1; ne++;
    ok = ack; a = 2; c = 0;
    if (!ack) begin
      for (int i = 0; i < MAXP; i++) begin
        c = 2 + d + i * (d + 1);
        if (!ok && c >= K) begin ok = 1; a = c + 1; end
      end
      if (!ok) begin kind = 2; endc = c + 1; end
    end
    if (ok) begin
      e_sel[ne] = 1; e_dat[ne] = (dev << 5) | attn; e_cyc[ne] = a; ne++;
      e_sel[ne] = 0; e_dat[ne] = 16'h0080; e_cyc[ne] = a + 1; ne++;
      if (!cmd) begin kind = 1; endc = a + 2; end
      else begin
        nw = lng ? 4 : 2; wcy = a + 2; stop = 0;
        for (int w = 0; w < nw; w++) begin
          if (!stop) begin
            e_sel[ne] = 2; e_dat[ne] = words[w]; e_cyc[ne] = wcy; ne++;
            ok = 0;
            for (int j = 0; j < MAXP; j++) begin
              c = wcy + 1 + d + j * (d + 1);
              if (!ok && c >= wcy + H) begin ok = 1; a = c; end
            end
            if (!ok) begin kind = 2; endc = c + 1; stop = 1; end
            else if (w == nw - 1) begin kind = 1; endc = a + 1; end
            else wcy = a + 1;
          end
        end
      end
    end
    // drive
    @(negedge clk);
    poll_mode = mode; dly_polled = DW'(dp); dly_irq = DW'(di);
    req_ack_rst = ack; req_cmd = cmd; req_long = lng; req_dev = 3'(dev);
    req_attn = 5'(attn); req_code = 5'(code); req_opts = 6'(opts);
    req_arg1 = 16'(words[1]); req_arg2 = 16'(words[2]); req_arg3 = 16'(words[3]);
    adp_busy = (K > 0); adp_cif_full = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    n = 0; ng = 0; fin = 0; gkind = 0; gend = 0; pulses = 0; cif_until = 0;
    while (n < 150 && !(fin && n >= gend + 4)) begin
      @(negedge clk);
      n++;
      if (reg_wr && ng < 16) begin
        g_sel[ng] = int'(reg_sel); g_dat[ng] = int'(reg_wdata); g_cyc[ng] = n; ng++;
      end
      if (seq_done || seq_timeout) begin
        pulses++;
        if (!fin) begin fin = 1; gend = n; gkind = seq_done ? 1 : 2; end
      end
      if (K > 0 && n == K) adp_busy = 1'b0;
      if (adp_cif_full && n >= cif_until) adp_cif_full = 1'b0;
      if (reg_wr && reg_sel == 2'd2 && H > 0) begin adp_cif_full = 1'b1; cif_until = n + H; end
      if (poke && n == 3) begin
        req_valid = 1'b1; req_dev = ~3'(dev); req_attn = ~5'(attn);
        req_ack_rst = 1'b1; req_cmd = ~cmd; req_code = ~5'(code);
      end
      if (poke && n == 5) req_valid = 1'b0;
    end
    adp_busy = 1'b0; adp_cif_full = 1'b0; req_valid = 1'b0;
    check(ng == ne, {tag, " write count"}, ng, ne);
    for (int i = 0; i < ne && i < ng; i++) begin
      check(g_sel[i] == e_sel[i], {tag, " register select"}, g_sel[i], e_sel[i]);
      check(g_dat[i] == e_dat[i], {tag, " write data"}, g_dat[i], e_dat[i]);
      check(g_cyc[i] == e_cyc[i], {tag, " write cycle"}, g_cyc[i], e_cyc[i]);
    end
    check(gkind == kind, {tag, " R10 R11 outcome"}, gkind, kind);
    check(gend == endc, {tag, " R11 outcome cycle"}, gend, endc);
    check(pulses == 1, {tag, " R11 single pulse"}, pulses, 1);
    @(negedge clk);
    check(!seq_busy && !reg_wr, {tag, " R1 idle after"}, int'(seq_busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ack_rst = 1'b0; req_cmd = 1'b0;
    req_long = 1'b0; poll_mode = 1'b1; req_attn = '0; req_code = '0;
    req_dev = '0; req_opts = '0; req_arg1 = '0; req_arg2 = '0; req_arg3 = '0;
    dly_polled = '0; dly_irq = '0; adp_busy = 1'b0; adp_cif_full = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!reg_wr && !seq_busy && !seq_done && !seq_timeout, "R12 reset outputs", int'(reg_wr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!reg_wr && !seq_busy && !seq_done && !seq_timeout, "R12 after release", int'(seq_busy), 0);
    // R2 R3 R5 R6: plain attention, every device, delays 0..3, controller device 7 included
    for (int dv = 0; dv < 8; dv++)
      run(1'b1, dv % 4, 7, 1'b0, 1'b0, 1'b0, dv, 3 + dv, 0, 0, 0, 0, 1'b0, "R5 attn sweep");
    // R3 mode selects the interrupt-driven delay
    run(1'b0, 5, 2, 1'b0, 1'b0, 1'b0, 2, 4, 0, 0, 0, 0, 1'b0, "R3 irq mode delay");
    run(1'b1, 6, 0, 1'b0, 1'b0, 1'b0, 2, 4, 0, 0, 0, 0, 1'b0, "R3 polled mode delay");
    // R3 R10 busy release point sweep, past the final check
    for (int k = 1; k <= 11; k++)
      run(1'b1, 1, 7, 1'b0, 1'b0, 1'b0, 1, 9, 0, 0, k, 0, 1'b0, "R3 R10 busy release");
    // R4 reset acknowledge skips poll even while busy
    run(1'b1, 3, 3, 1'b1, 1'b0, 1'b0, 7, 10, 0, 0, 1000, 0, 1'b0, "R4 ack skip");
    run(1'b0, 2, 2, 1'b1, 1'b1, 1'b0, 7, 1, 4, 5, 1000, 0, 1'b0, "R4 ack with command");
    // R7 R8 R9 R10 command blocks, both lengths, acceptance delay sweep
    for (int hl = 0; hl < 2; hl++)
      for (int hh = 0; hh < 14; hh++)
        run(1'b1, 2, 7, 1'b0, 1'b1, hl[0], hh % 8, 1, (hh * 3) % 32, 6'h02 + hh,
            0, hh, 1'b0, "R7 R8 R9 command block");
    run(1'b0, 7, 0, 1'b0, 1'b1, 1'b1, 6, 1, 31, 63, 0, 0, 1'b0, "R8 long zero delay");
    // R1 requests while busy are ignored
    run(1'b1, 3, 3, 1'b0, 1'b1, 1'b1, 2, 1, 9, 2, 4, 2, 1'b1, "R1 poke while busy");
    run(1'b1, 2, 2, 1'b0, 1'b0, 1'b0, 5, 6, 0, 0, 0, 0, 1'b1, "R1 poke attention");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule